// File: doc/BRIEF.md
# Interval and Watchdog Timer

This block keeps an 8-bit up-counter that advances on strobes from one of four prescaler taps. A two-bit selector field picks the tap. The counter has three uses:

- **Interval timer.** When the counter wraps from 255 to 0 it sets a sticky interrupt request flag.
- **Watchdog.** Software can arm the watchdog with a set-only strobe. Once armed, a wrap produces a one-cycle internal reset instead of an interrupt.
- **Standby-release wait.** A standby-release indication restarts the count. The next wrap then signals the clock generator that the oscillation-settling wait is over.

All pins are plain control strobes or levels; there is no streaming payload, so no valid/ready handshake applies and the block never applies back-pressure.

A mode write takes effect at the clock edge where `mode_we` is high. Prescaler strobes in `tap_tick` are expected to be one cycle wide.

Top module: `ivt_wdt`

## Requirements
- R1: After `rst_n` is low, `count`, `irq_flag`, `int_rst`, `wait_done`, `wdt_on` and `mode_rd` are all 0.
- R2: `mode_wdata[1:0]` written with `mode_we` picks which bit of `tap_tick` advances the counter. That takes effect from the next cycle. `count` goes up by exactly one on each cycle the selected tap is 1 and holds otherwise; strobes on unselected taps have no effect.
- R3: A write with `mode_wdata[2]`=1 sets `count` to 0 at that edge, overriding a tick in the same cycle. `mode_rd` returns {1'b0, 1'b0, selector}, so bit 2 always reads 0.
- R4: In interval mode (`wdt_on`=0, no wait in progress), a tick while `count`=255 wraps it to 0 and sets `irq_flag` from the next cycle.
- R5: `irq_flag` stays 1 until `irq_ack` is high; a new overflow in the same cycle as `irq_ack` keeps it at 1.
- R6: A pulse on `wdt_arm` sets `wdt_on`. Mode writes never clear it; only `rst_n` or the block's own internal reset does.
- R7: With `wdt_on`=1 and no wait in progress, an overflow makes `int_rst` 1 for exactly one cycle and sets no interrupt. That same edge returns the selector, `wdt_on` and `irq_flag` to 0; the count wraps to 0.
- R8: A pulse on `stby_rel` clears `count` and starts a wait. The next overflow gives a one-cycle `wait_done` and ends the wait, with no interrupt and no internal reset.
- R9: `count` shows the live counter value on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset |
| tap_tick | input | 4 | One-cycle prescaler strobes, bit i for tap i |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Write data: [1:0] tap selector, [2] counter clear, [3] unused |
| wdt_arm | input | 1 | Bit-set strobe that arms the watchdog |
| irq_ack | input | 1 | Clears the interrupt request flag |
| stby_rel | input | 1 | Standby-release indication, starts the settling wait |
| mode_rd | output | 4 | Mode register readback |
| count | output | 8 | Current counter value |
| irq_flag | output | 1 | Interval interrupt request flag |
| int_rst | output | 1 | One-cycle internal reset pulse |
| wait_done | output | 1 | One-cycle end-of-wait pulse to the clock generator |
| wdt_on | output | 1 | Watchdog armed |

## Verification
The assertions check on every cycle that:
- the count holds when no selected tick and no clear arrives;
- a clear leaves the count at 0;
- an interval-mode overflow raises the flag;
- an armed watchdog only disarms through its own reset pulse;
- the reset pulse and the end-of-wait pulse last one cycle.

Some behaviours only the bench scenarios can show:
- tap selection across the four taps;
- an acknowledge colliding with an overflow;
- a clear colliding with a tick;
- a standby release during an armed watchdog;
- the full restore of the mode register after an internal reset.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W    = 8;
  localparam int NUM_TAPS = 4;
  localparam int SEL_W    = $clog2(NUM_TAPS);
  localparam int MODE_W   = 4;
  localparam int CLR_BIT  = 2;

  typedef logic [SEL_W-1:0] tap_sel_t;

  typedef enum logic [1:0] {
    PH_INTERVAL = 2'd0,
    PH_WATCHDOG = 2'd1,
    PH_WAIT     = 2'd2
  } ivt_phase_e;
endpackage

// File: rtl/ivt_tap_sel.sv
module ivt_tap_sel #(
  parameter int NUM_TAPS = 4,
  parameter int SEL_W    = 2
) (
  input  logic [NUM_TAPS-1:0] taps,
  input  logic [SEL_W-1:0]    sel,
  output logic                tick
);
  logic [NUM_TAPS-1:0] gated;

  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign gated[i] = taps[i] & (sel == SEL_W'(i));
  end

  assign tick = |gated;
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // A clear suppresses the overflow of the same cycle.
  assign ovf = inc & ~clr & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_we,
  input  logic [MODE_W-1:0] mode_wdata,
  input  logic              wdt_arm,
  input  logic              irq_ack,
  input  logic              stby_rel,
  input  logic              ovf,
  output tap_sel_t          sel,
  output logic              wdt_on,
  output logic              waiting,
  output logic              irq_flag,
  output logic              int_rst,
  output logic              wait_done
);
  ivt_phase_e phase;
  logic       rst_fire;
  logic       irq_fire;
  logic       wait_fire;

  always_comb begin
    if (waiting)     phase = PH_WAIT;
    else if (wdt_on) phase = PH_WATCHDOG;
    else             phase = PH_INTERVAL;
  end

  assign rst_fire  = ovf & (phase == PH_WATCHDOG);
  assign irq_fire  = ovf & (phase == PH_INTERVAL);
  assign wait_fire = ovf & (phase == PH_WAIT);

  // Mode selector: the internal reset wins over a write in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel <= '0;
    else if (rst_fire) sel <= '0;
    else if (mode_we)  sel <= mode_wdata[SEL_W-1:0];
  end

  // Watchdog enable: set-only from software.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wdt_on <= 1'b0;
    else if (rst_fire) wdt_on <= 1'b0;
    else if (wdt_arm)  wdt_on <= 1'b1;
  end

  // Interrupt flag: a set beats an acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_flag <= 1'b0;
    else if (rst_fire) irq_flag <= 1'b0;
    else if (irq_fire) irq_flag <= 1'b1;
    else if (irq_ack)  irq_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         waiting <= 1'b0;
    else if (stby_rel)  waiting <= 1'b1;
    else if (wait_fire) waiting <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_rst   <= 1'b0;
      wait_done <= 1'b0;
    end else begin
      int_rst   <= rst_fire;
      wait_done <= wait_fire;
    end
  end
endmodule

// File: rtl/ivt_wdt.sv
module ivt_wdt
  import ivt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TAPS-1:0] tap_tick,
  input  logic                mode_we,
  input  logic [MODE_W-1:0]   mode_wdata,
  input  logic                wdt_arm,
  input  logic                irq_ack,
  input  logic                stby_rel,
  output logic [MODE_W-1:0]   mode_rd,
  output logic [CNT_W-1:0]    count,
  output logic                irq_flag,
  output logic                int_rst,
  output logic                wait_done,
  output logic                wdt_on
);
  tap_sel_t sel_q;
  logic     tick_w;
  logic     clr_w;
  logic     ovf_w;
  logic     waiting_w;

  assign clr_w = (mode_we & mode_wdata[CLR_BIT]) | stby_rel;

  ivt_tap_sel #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_sel (
    .taps (tap_tick),
    .sel  (sel_q),
    .tick (tick_w)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_w),
    .inc   (tick_w),
    .cnt   (count),
    .ovf   (ovf_w)
  );

  ivt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .wdt_arm    (wdt_arm),
    .irq_ack    (irq_ack),
    .stby_rel   (stby_rel),
    .ovf        (ovf_w),
    .sel        (sel_q),
    .wdt_on     (wdt_on),
    .waiting    (waiting_w),
    .irq_flag   (irq_flag),
    .int_rst    (int_rst),
    .wait_done  (wait_done)
  );

  assign mode_rd = MODE_W'(sel_q);
endmodule

// File: rtl/ivt_wdt_chk.sv
module ivt_wdt_chk
  import ivt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_w,
  input logic             clr_w,
  input logic             ovf_w,
  input logic             waiting_w,
  input logic [CNT_W-1:0] count,
  input logic             irq_flag,
  input logic             int_rst,
  input logic             wait_done,
  input logic             wdt_on
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_w && !clr_w) |=> $stable(count));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_w |=> (count == '0));

  assert_ovf_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_w && !wdt_on && !waiting_w) |=> irq_flag);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_on |=> (wdt_on || int_rst));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_rst |=> !int_rst);

  assert_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_w && waiting_w) |=> (wait_done && !int_rst));

  assert_wait_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wait_done |=> !wait_done);
endmodule

bind ivt_wdt ivt_wdt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_w    (tick_w),
  .clr_w     (clr_w),
  .ovf_w     (ovf_w),
  .waiting_w (waiting_w),
  .count     (count),
  .irq_flag  (irq_flag),
  .int_rst   (int_rst),
  .wait_done (wait_done),
  .wdt_on    (wdt_on)
);

// File: tb/ivt_wdt_tb.sv
module ivt_wdt_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tap_tick = '0;
  logic       mode_we = 1'b0;
  logic [3:0] mode_wdata = '0;
  logic       wdt_arm = 1'b0;
  logic       irq_ack = 1'b0;
  logic       stby_rel = 1'b0;
  logic [3:0] mode_rd;
  logic [7:0] count;
  logic       irq_flag, int_rst, wait_done, wdt_on;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // Reference model state
  logic [7:0] m_cnt;
  logic [1:0] m_sel;
  logic       m_irq, m_wdt, m_wait, m_rst, m_wd;

  always #4 clk = ~clk;

  ivt_wdt u_dut (
    .clk(clk), .rst_n(rst_n), .tap_tick(tap_tick), .mode_we(mode_we),
    .mode_wdata(mode_wdata), .wdt_arm(wdt_arm), .irq_ack(irq_ack),
    .stby_rel(stby_rel), .mode_rd(mode_rd), .count(count),
    .irq_flag(irq_flag), .int_rst(int_rst), .wait_done(wait_done),
    .wdt_on(wdt_on)
  );

  task automatic check(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, "/R9"}, "count", count, m_cnt);
    check({tag, "/R5"}, "irq_flag", irq_flag, m_irq);
    check({tag, "/R7"}, "int_rst", int_rst, m_rst);
    check({tag, "/R8"}, "wait_done", wait_done, m_wd);
    check({tag, "/R6"}, "wdt_on", wdt_on, m_wdt);
    check({tag, "/R3"}, "mode_rd", mode_rd, {2'b00, m_sel});
  endtask

  // Next-state rules from the requirements
  task automatic model_step();
    logic tick, clr, ovf, rstp, wdone, ifire;
    tick  = tap_tick[m_sel];
    clr   = (mode_we && mode_wdata[2]) || stby_rel;
    ovf   = tick && !clr && (m_cnt == 8'hFF);
    rstp  = ovf && m_wdt && !m_wait;
    wdone = ovf && m_wait;
    ifire = ovf && !m_wdt && !m_wait;
    m_cnt = clr ? 8'h00 : (tick ? m_cnt + 8'h01 : m_cnt);
    if (rstp) begin
      m_sel = 2'b00; m_wdt = 1'b0; m_irq = 1'b0;
    end else begin
      if (mode_we) m_sel = mode_wdata[1:0];
      if (wdt_arm) m_wdt = 1'b1;
      if (ifire) m_irq = 1'b1;
      else if (irq_ack) m_irq = 1'b0;
    end
    if (stby_rel) m_wait = 1'b1;
    else if (wdone) m_wait = 1'b0;
    m_rst = rstp;
    m_wd  = wdone;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_step();
    #1;
    check_all(tag);
    @(negedge clk);
    tap_tick = '0; mode_we = 0; mode_wdata = '0;
    wdt_arm = 0; irq_ack = 0; stby_rel = 0;
  endtask

  task automatic write_mode(logic [1:0] sel, logic clr, string tag);
    mode_we = 1; mode_wdata = {1'b0, clr, sel};
    step(tag);
  endtask

  task automatic ticks(int n, logic [3:0] pattern, string tag);
    for (int i = 0; i < n; i++) begin
      tap_tick = pattern;
      step(tag);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_sel = 0; m_irq = 0; m_wdt = 0; m_wait = 0; m_rst = 0; m_wd = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check_all("R1 after release");

    // R2: only the selected tap counts
    ticks(5, 4'b1110, "R2 unselected taps");
    ticks(7, 4'b0001, "R2 tap0");
    write_mode(2'd2, 1'b0, "R2 select tap2");
    ticks(4, 4'b1011, "R2 tap2 unselected");
    ticks(3, 4'b0100, "R2 tap2");

    // R3: clear wins over a simultaneous tick
    tap_tick = 4'b0100; mode_we = 1; mode_wdata = 4'b0110;
    step("R3 clear vs tick");

    // R4/R5: overflow sets flag, ack collides with overflow
    ticks(255, 4'b0100, "R4 count up");
    irq_ack = 1; tap_tick = 4'b0100;
    step("R5 ack vs overflow");
    step("R5 hold");
    ticks(3, 4'b0000, "R5 hold idle");
    irq_ack = 1;
    step("R5 ack");

    // R6: writes do not disarm; R7: internal reset
    wdt_arm = 1;
    step("R6 arm");
    write_mode(2'd3, 1'b1, "R6 write does not clear");
    ticks(256, 4'b1000, "R7 watchdog run");
    step("R7 pulse ends");

    // R8: wait during armed watchdog
    wdt_arm = 1;
    step("R8 arm again");
    ticks(10, 4'b0001, "R8 pre");
    stby_rel = 1; tap_tick = 4'b0001;
    step("R8 release");
    ticks(256, 4'b0001, "R8 wait run");
    step("R8 pulse ends");

    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      tap_tick   = 4'($urandom());
      mode_we    = ($urandom_range(0, 19) == 0);
      mode_wdata = {1'b0, ($urandom_range(0, 3) == 0), 2'($urandom())};
      wdt_arm    = ($urandom_range(0, 399) == 0);
      irq_ack    = ($urandom_range(0, 9) == 0);
      stby_rel   = ($urandom_range(0, 599) == 0);
      step("random R2 R4 R7 R8");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule